// File: doc/BRIEF.md
# Cross-Domain Timer Snapshot Register

This block keeps a free-running up-counter in a timer clock domain and gives a host on a separate bus clock a coherent way to read it. The host writes a 1 to the capture register. The request crosses into the timer domain as a toggle, and the counter value is latched there on the next edge where the selected rate is active. An acknowledge toggle then returns to the bus domain. Only when that acknowledge arrives does the bus side copy the held value into its read shadow and raise a valid flag. Software polls the flag instead of waiting a guessed delay. The time to complete therefore depends on the selected timer rate.

The timer clock is one fast clock with five rate enables. Four fast divided rates and one slow 32768 Hz rate are modeled as enable strobes driven from outside. A select register picks which enable advances the counter. The live counter can also be read directly. That value crosses the clock boundary unsynchronized, so software re-reads it until two successive reads agree.

Top module: `tmr_snap`

## Requirements
- R1: The counter advances by exactly one on each timer clock edge where the enable of the selected rate is high, and holds otherwise, independently of bus activity.
- R2: The select register (address 3, bits 2:0, reset 0) picks the rate. Codes 0 to 3 select the enables rate_en[0] to rate_en[3], the four fast rates. Every code of 4 or more selects rate_en[4], the slow rate. Enables that are not selected have no effect on the counter.
- R3: Writing a word with bit 0 set to the capture register (address 0) while no capture is pending starts a capture. The valid bit (address 1, bit 0) reads 0 from the next bus edge. A write with bit 0 clear has no effect.
- R4: The capture latches the counter value present before the increment of the first selected-rate edge after the request reaches the timer domain. While the selected enable stays low, no capture completes.
- R5: Once the acknowledge returns, valid reads 1 and address 0 returns the captured value.
- R6: While valid is 0, address 0 returns the previous snapshot unchanged. That value is 0 after reset.
- R7: A capture write made while a capture is pending is ignored.
- R8: Address 2 returns the live counter directly. It may be torn while the counter runs, and is exact while the counter is stopped.
- R9: The counter (CNT_W bits, 32 by default) wraps from all ones to zero without any flag.
- R10: After reset, all four registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus-domain reset, active low, synchronous |
| bus_wr | input | 1 | Single-cycle register write strobe |
| bus_addr | input | 2 | Register address: 0 capture, 1 status, 2 live count, 3 select |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| tmr_clk | input | 1 | Timer clock, asynchronous to bus_clk |
| tmr_rst_n | input | 1 | Timer-domain reset, active low, synchronous |
| rate_en | input | 5 | Rate enables in the timer domain: 0..3 fast rates, 4 slow rate |

## Verification
The hardest situation to reach from the ports is a capture that has been requested but is held back in the timer domain. In that window, valid is 0 and the shadow must still show the older snapshot. The bench creates this by stopping every rate enable before it writes the request. It waits long enough for both synchronizers to settle, then checks that the capture has not completed and that the old value is still returned. It then releases exactly one selected edge, so the captured value is known exactly. A long run of ticks on a narrow counter carries the count past all ones.

// File: rtl/tmr_snap_pkg.sv
`timescale 1ns/1ps
// Shared constants for the timer snapshot block.
// Assumes five rate enables, the last one being the slow rate.
package tmr_snap_pkg;
    localparam int NUM_RATES = 5;
    localparam int SEL_W     = 3;
    localparam int ADDR_W    = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CAP  = 2'd0,
        REG_STAT = 2'd1,
        REG_LIVE = 2'd2,
        REG_SEL  = 2'd3
    } reg_addr_e;

    // Map a select code to a rate enable index; large codes pick the slow rate.
    function automatic int unsigned sel_to_idx(input logic [SEL_W-1:0] sel);
        if (int'(sel) >= NUM_RATES - 1) return NUM_RATES - 1;
        return int'(sel);
    endfunction
endpackage

// File: rtl/tmr_snap_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer, W bits wide, into the domain of clk.
// Assumes each bit changes rarely (toggle or quasi-static), so there is no bus coherency issue.
module tmr_snap_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Pass d through two flops in the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/tmr_snap_core.sv
`timescale 1ns/1ps
// Timer-domain counter and capture latch.
// Assumes req_s and sel_s are already synchronized to clk. The snapshot is held stable
// until the next request, so the bus side may sample it after the acknowledge arrives.
module tmr_snap_core
    import tmr_snap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RATES-1:0] rate_en,
    input  logic [SEL_W-1:0]     sel_s,
    input  logic                 req_s,
    output logic [CNT_W-1:0]     cnt,
    output logic [CNT_W-1:0]     snap,
    output logic                 ack_tgl,
    output logic                 tick
);
    logic req_prev;
    logic pend;
    logic req_edge;

    // Pick the enable of the selected rate.
    always_comb tick = rate_en[sel_to_idx(sel_s)];

    assign req_edge = req_s ^ req_prev;

    // Count on selected ticks; latch the count on the first tick after a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            snap     <= '0;
            ack_tgl  <= 1'b0;
            req_prev <= 1'b0;
            pend     <= 1'b0;
        end else begin
            req_prev <= req_s;
            if (tick) cnt <= cnt + 1'b1;
            if ((pend || req_edge) && tick) begin
                snap    <= cnt;
                ack_tgl <= ~ack_tgl;
                pend    <= 1'b0;
            end else if (req_edge) begin
                pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_snap_regs.sv
`timescale 1ns/1ps
// Bus-domain register file: capture request, valid flag, snapshot shadow, rate select, reads.
// Assumes ack_s is synchronized to clk. The snap input is stable whenever the acknowledge
// edge is seen. The live count is read without synchronization and may be torn.
module tmr_snap_regs
    import tmr_snap_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ack_s,
    input  logic [CNT_W-1:0]  snap,
    input  logic [CNT_W-1:0]  live_cnt,
    output logic              req_tgl,
    output logic [SEL_W-1:0]  sel,
    output logic              vld,
    output logic              busy,
    output logic [CNT_W-1:0]  shadow
);
    logic ack_prev;
    logic ack_edge;
    logic wr_cap;
    logic unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:SEL_W];
    assign wr_cap   = wr && (addr == REG_CAP) && wdata[0];
    assign ack_edge = ack_s ^ ack_prev;

    // Start a capture when idle; finish it when the acknowledge edge arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_tgl  <= 1'b0;
            busy     <= 1'b0;
            vld      <= 1'b0;
            shadow   <= '0;
            ack_prev <= 1'b0;
        end else begin
            ack_prev <= ack_s;
            if (wr_cap && !busy) begin
                req_tgl <= ~req_tgl;
                busy    <= 1'b1;
                vld     <= 1'b0;
            end else if (ack_edge) begin
                busy   <= 1'b0;
                vld    <= 1'b1;
                shadow <= snap;
            end
        end
    end

    // Hold the rate select written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) sel <= '0;
        else if (wr && addr == REG_SEL) sel <= wdata[SEL_W-1:0];
    end

    // Return the addressed register.
    always_comb begin
        case (addr)
            REG_CAP:  rdata = DATA_W'(shadow);
            REG_STAT: rdata = DATA_W'(vld);
            REG_LIVE: rdata = DATA_W'(live_cnt);
            default:  rdata = DATA_W'(sel);
        endcase
    end
endmodule

// File: rtl/tmr_snap.sv
`timescale 1ns/1ps
// Timer with a cross-domain snapshot register.
// Request and acknowledge cross as toggles through two-flop synchronizers. The select
// register crosses as a quasi-static value. Rates are enables on a single timer clock.
module tmr_snap
    import tmr_snap_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic                 bus_clk,
    input  logic                 bus_rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 tmr_clk,
    input  logic                 tmr_rst_n,
    input  logic [NUM_RATES-1:0] rate_en
);
    logic             req_tgl, req_s, ack_tgl, ack_s;
    logic             cap_busy, cap_vld, tmr_tick;
    logic [SEL_W-1:0] sel, sel_s;
    logic [CNT_W-1:0] cnt, snap, shadow;

    tmr_snap_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_regs (
        .clk(bus_clk), .rst_n(bus_rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .ack_s(ack_s), .snap(snap),
        .live_cnt(cnt), .req_tgl(req_tgl), .sel(sel), .vld(cap_vld),
        .busy(cap_busy), .shadow(shadow)
    );

    tmr_snap_sync #(.W(1)) i_req_sync (
        .clk(tmr_clk), .rst_n(tmr_rst_n), .d(req_tgl), .q(req_s)
    );

    tmr_snap_sync #(.W(SEL_W)) i_sel_sync (
        .clk(tmr_clk), .rst_n(tmr_rst_n), .d(sel), .q(sel_s)
    );

    tmr_snap_sync #(.W(1)) i_ack_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_tgl), .q(ack_s)
    );

    tmr_snap_core #(.CNT_W(CNT_W)) i_core (
        .clk(tmr_clk), .rst_n(tmr_rst_n), .rate_en(rate_en), .sel_s(sel_s),
        .req_s(req_s), .cnt(cnt), .snap(snap), .ack_tgl(ack_tgl), .tick(tmr_tick)
    );
endmodule

// File: rtl/tmr_snap_chk.sv
`timescale 1ns/1ps
// Assertion checker for tmr_snap, attached by bind. Bus-side properties use bus_clk;
// counter properties use tmr_clk.
module tmr_snap_chk
    import tmr_snap_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              bus_clk,
    input logic              bus_rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              cap_busy,
    input logic              cap_vld,
    input logic              req_tgl,
    input logic [CNT_W-1:0]  shadow,
    input logic              tmr_clk,
    input logic              tmr_rst_n,
    input logic              tmr_tick,
    input logic [CNT_W-1:0]  cnt
);
    logic cap_wr;
    assign cap_wr = bus_wr && (bus_addr == REG_CAP) && bus_wdata[0];

    assert_cnt_step_R1: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        tmr_tick |=> cnt == CNT_W'($past(cnt) + 1'b1));

    assert_cnt_hold_R1: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        !tmr_tick |=> $stable(cnt));

    assert_req_clears_valid_R3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        cap_wr && !cap_busy |=> !cap_vld);

    assert_valid_after_pending_R5: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $rose(cap_vld) |-> $past(cap_busy));

    assert_shadow_hold_R6: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !cap_vld |=> (cap_vld || $stable(shadow)));

    assert_pending_write_ignored_R7: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        cap_wr && cap_busy |=> $stable(req_tgl));
endmodule

bind tmr_snap tmr_snap_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cap_busy(cap_busy), .cap_vld(cap_vld), .req_tgl(req_tgl),
    .shadow(shadow), .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n), .tmr_tick(tmr_tick),
    .cnt(cnt)
);

// File: tb/test_tmr_snap.sv
`timescale 1ns/1ps
// Bench for tmr_snap: a vector table walked by one loop, then directed corner tests.
module test_tmr_snap;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 8;
    localparam int NV     = 9;
    // Columns: select code, enable mask during the run, run length, expected snapshot.
    localparam int V_SEL  [NV] = '{0, 1, 1, 2, 3, 4, 7, 0, 0};
    localparam int V_MASK [NV] = '{5'b00001, 5'b00001, 5'b00010, 5'b11111, 5'b01000,
                                   5'b10000, 5'b10000, 5'b11110, 5'b00001};
    localparam int V_N    [NV] = '{5, 7, 10, 3, 30, 2, 4, 9, 200};
    localparam int V_SNAP [NV] = '{5, 6, 17, 21, 52, 55, 60, 61, 6};

    logic              bus_clk = 1'b0, tmr_clk = 1'b0;
    logic              bus_rst_n = 1'b0, tmr_rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [1:0]        bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [4:0]        rate_en = '0;
    int total = 0, bad = 0;
    bit done = 0;

    always #4 bus_clk = ~bus_clk;
    always #5 tmr_clk = ~tmr_clk;

    tmr_snap #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_tmr_snap (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_clk(tmr_clk),
        .tmr_rst_n(tmr_rst_n), .rate_en(rate_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge bus_clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input logic [4:0] mask, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge tmr_clk);
            rate_en = mask;
        end
        @(negedge tmr_clk);
        rate_en = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge bus_clk);
    endtask

    function automatic logic [4:0] sel_mask(input int s);
        return 5'b1 << ((s >= 4) ? 4 : s);
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] prev_snap;
        repeat (4) @(negedge bus_clk);
        bus_rst_n = 1'b1; tmr_rst_n = 1'b1;
        idle(2);
        // R10: reset values.
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check("R10 reset register", d, 0);
        end
        prev_snap = 0;
        // Table walk: R1, R2, R4, R5, R6, R8, R9.
        for (int v = 0; v < NV; v++) begin
            wr(2'd3, 32'(V_SEL[v]));
            rd(2'd3, d);
            check("R2 select readback", d, 32'(V_SEL[v]));
            idle(6);
            ticks(5'(V_MASK[v]), V_N[v]);
            idle(2);
            rd(2'd2, d);
            check("R1/R8/R9 live count stopped", d, 32'(V_SNAP[v]));
            wr(2'd0, 32'd1);
            rd(2'd1, d);
            check("R3 valid cleared by request", d, 0);
            idle(10);
            rd(2'd1, d);
            check("R4 no completion without tick", d, 0);
            rd(2'd0, d);
            check("R6 old snapshot while invalid", d, prev_snap);
            ticks(sel_mask(V_SEL[v]), 1);
            idle(10);
            rd(2'd1, d);
            check("R5 valid after acknowledge", d, 1);
            rd(2'd0, d);
            check("R4/R5 snapshot value", d, 32'(V_SNAP[v]));
            prev_snap = 32'(V_SNAP[v]);
        end
        // Counter is now 7 with select 0.
        // R3: a write with bit 0 clear starts nothing.
        wr(2'd0, 32'd0);
        rd(2'd1, d);
        check("R3 zero write keeps valid", d, 1);
        ticks(5'b00001, 3);
        idle(10);
        rd(2'd0, d);
        check("R3 zero write keeps snapshot", d, 6);
        // R7: a second request while pending is ignored; the count is 10 here.
        wr(2'd0, 32'd1);
        idle(10);
        wr(2'd0, 32'd1);
        idle(10);
        ticks(5'b00001, 1);
        idle(10);
        rd(2'd1, d);
        check("R7 valid after single capture", d, 1);
        rd(2'd0, d);
        check("R7 snapshot of first request", d, 10);
        ticks(5'b00001, 2);
        idle(10);
        rd(2'd1, d);
        check("R7 no second capture valid", d, 1);
        rd(2'd0, d);
        check("R7 no second capture value", d, 10);
        // R8: software two-read loop on a stopped counter returns the exact count.
        begin
            logic [31:0] a1, a2;
            int tries = 0;
            do begin
                rd(2'd2, a1);
                rd(2'd2, a2);
                tries++;
            end while (a1 != a2 && tries < 10);
            check("R8 stable double read", a1, 13);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule